// File: doc/BRIEF.md
# Dual-Edge 1-to-16 Serial Deserializer

This block turns a serial bit stream into 16-bit parallel words. The sampling clock runs at half the bit rate, and a bit is captured on each of its edges. The block therefore takes in two bits per clock cycle. The bit captured on the rising edge (`bit_rise`) is the earlier of the two, and the bit captured on the falling edge (`bit_fall`) is the later one. Eight clock cycles make one 16-bit word. The completed word is placed in an output register, and a one-cycle strobe marks it, all in the same half-rate clock domain.

A 3-bit cycle counter marks the word boundary. A synchronous alignment input (`align`) clears this counter and the partial word. Several instances that release `align` on the same edge therefore frame their words identically. A run-time order select (`lane_order`) chooses whether output lane 0 or output lane 15 carries the earliest-received bit of each word. The select is taken only on the cycle that completes a word, so a word is never emitted with mixed ordering.

The asynchronous active-low reset `rst_n` takes effect at once. Its release is synchronized to `clk`, so it ends two rising edges after `rst_n` goes high.

Top module: `ddr_deser16`

## Requirements
- R1: While `rst_n` is low, `word_o` is 16'h0000 and `word_vld_o` is 0. Both take these values immediately on assertion, without waiting for a clock edge.
- R2: Once aligned, `word_vld_o` is high for exactly one cycle in every 8 cycles and is never high on two consecutive cycles.
- R3: Each word is made of the 16 bits received over 8 consecutive cycles. Within each cycle, `bit_rise` counts as earlier than `bit_fall`.
- R4: With `lane_order`=1 at the word boundary, bit 15 of `word_o` holds the earliest-received bit, and bit 0 holds the `bit_fall` of the eighth cycle.
- R5: With `lane_order`=0 at the word boundary, bit 0 of `word_o` holds the earliest-received bit, and bit 15 holds the latest.
- R6: `lane_order` is sampled only on the rising edge that completes a word. Any value it takes during the other 7 cycles has no effect on the word.
- R7: A cycle with `align`=1 clears the cycle counter and the partial word, and `word_vld_o` is 0 in the cycle after it. After `align` is released, the first strobe comes 8 cycles later and carries exactly the 16 bits driven in those 8 cycles.
- R8: `word_o` changes only in a cycle where `word_vld_o` is high, and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| align | input | 1 | Synchronous word-boundary alignment, active high |
| bit_rise | input | 1 | Serial bit captured on the rising edge (earlier bit) |
| bit_fall | input | 1 | Serial bit captured on the falling edge (later bit) |
| lane_order | input | 1 | 1: lane 15 holds the first bit; 0: lane 0 holds the first bit |
| word_o | output | 16 | Parallel output word |
| word_vld_o | output | 1 | One-cycle strobe marking a new word on `word_o` |

## Verification
A pair of bits driven in cycle k of a word reaches `word_o` on the rising edge that ends cycle 7. The strobe is therefore visible during cycle 8, which is also cycle 0 of the next word. The bench drives inputs and samples outputs on falling edges. It checks each word at the falling edge that follows its eighth input pair, and it checks the hold and strobe-low conditions at the falling edge in the middle of the next word. Alignment is counted from the first rising edge with `align` low. The asynchronous reset is checked one time step after `rst_n` falls, before any clock edge.

// File: rtl/deser_pkg.sv
package deser_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned BITS_PER_CYC = 2;

  typedef enum logic {
    ORD_FIRST_LOW  = 1'b0,
    ORD_FIRST_HIGH = 1'b1
  } lane_order_e;
endpackage

// File: rtl/deser_rst_sync.sv
module deser_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_n;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/deser_phase_cnt.sv
module deser_phase_cnt #(
  parameter int unsigned CYCLES = 8,
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          align,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;

  always_comb begin
    if (align) begin
      cnt_n = '0;
    end else if (cnt_q == LAST) begin
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST);

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    align |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/deser_shreg.sv
module deser_shreg #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned STEP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             align,
  input  logic [STEP-1:0]  din,
  output logic [WIDTH-1:0] word_next_o
);
  logic [WIDTH-1:0] sr_q;
  logic [WIDTH-1:0] sr_n;
  logic [WIDTH-1:0] shifted;

  always_comb begin
    shifted = {sr_q[WIDTH-STEP-1:0], din};
    sr_n    = align ? '0 : shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_n;
    end
  end

  assign word_next_o = shifted;

  AST_SR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    align |=> (sr_q == '0)); // R7
endmodule

// File: rtl/deser_word_out.sv
module deser_word_out
  import deser_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             order,
  input  logic [WIDTH-1:0] word_in,
  output logic [WIDTH-1:0] word_o,
  output logic             vld_o
);
  logic [WIDTH-1:0] reversed;
  logic [WIDTH-1:0] word_q;
  logic [WIDTH-1:0] word_n;
  logic             vld_q;
  logic             vld_n;

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign reversed[i] = word_in[WIDTH-1-i];
  end

  always_comb begin
    word_n = word_q;
    if (load) begin
      word_n = (lane_order_e'(order) == ORD_FIRST_HIGH) ? word_in : reversed;
    end
    vld_n = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      word_q <= word_n;
      vld_q  <= vld_n;
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(word_q)); // R8
endmodule

// File: rtl/ddr_deser16.sv
module ddr_deser16
  import deser_pkg::*;
#(
  parameter int unsigned WIDTH = WORD_W,
  parameter int unsigned STEP  = BITS_PER_CYC,
  localparam int unsigned CYCLES = WIDTH / STEP,
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             align,
  input  logic             bit_rise,
  input  logic             bit_fall,
  input  logic             lane_order,
  output logic [WIDTH-1:0] word_o,
  output logic             word_vld_o
);
  logic             rst_n_int;
  logic [CW-1:0]    phase;
  logic             phase_last;
  logic             load;
  logic [STEP-1:0]  din;
  logic [WIDTH-1:0] word_next;

  assign din  = {bit_rise, bit_fall};
  assign load = phase_last && !align;

  deser_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  deser_phase_cnt #(.CYCLES(CYCLES)) phase_cnt_i (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .align  (align),
    .cnt_o  (phase),
    .last_o (phase_last)
  );

  deser_shreg #(.WIDTH(WIDTH), .STEP(STEP)) shreg_i (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .align       (align),
    .din         (din),
    .word_next_o (word_next)
  );

  deser_word_out #(.WIDTH(WIDTH)) word_out_i (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load    (load),
    .order   (lane_order),
    .word_in (word_next),
    .word_o  (word_o),
    .vld_o   (word_vld_o)
  );

  AST_VLD_SPACING: assert property (@(posedge clk) disable iff (!rst_n_int)
    word_vld_o |=> !word_vld_o); // R2
  AST_VLD_PHASE: assert property (@(posedge clk) disable iff (!rst_n_int)
    word_vld_o |-> (phase == '0)); // R2
  AST_ALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n_int)
    align |=> !word_vld_o); // R7
  AST_RESET_OUT: assert property (@(posedge clk)
    !rst_n |-> (word_o == '0 && !word_vld_o)); // R1
endmodule

// File: tb/ddr_deser16_tb_top.sv
module ddr_deser16_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        align = 1'b0;
  logic        bit_rise = 1'b0;
  logic        bit_fall = 1'b0;
  logic        lane_order = 1'b0;
  logic [15:0] word_o;
  logic        word_vld_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ddr_deser16 dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .align      (align),
    .bit_rise   (bit_rise),
    .bit_fall   (bit_fall),
    .lane_order (lane_order),
    .word_o     (word_o),
    .word_vld_o (word_vld_o)
  );

  typedef struct packed {
    logic        ord;
    logic [15:0] stream;
    logic [15:0] expect_w;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h8000, 16'h8000},
    '{1'b0, 16'h8000, 16'h0001},
    '{1'b1, 16'hA5C3, 16'hA5C3},
    '{1'b0, 16'hA5C3, 16'hC3A5},
    '{1'b0, 16'h1234, 16'h2C48},
    '{1'b1, 16'hFFFF, 16'hFFFF},
    '{1'b0, 16'hF0F0, 16'h0F0F}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  // Drives 8 pairs starting at the current falling edge; ends on the falling
  // edge after the word-completing rising edge.
  task automatic drive_word(input logic [15:0] stream, input logic ord_mid,
                            input logic ord_end, input bit hold_chk,
                            input logic [15:0] hold_val);
    for (int k = 0; k < 8; k++) begin
      if (k == 4) begin
        check("R2 strobe low mid-word", {31'd0, word_vld_o}, 32'd0);
        if (hold_chk) check("R8 word held", {16'd0, word_o}, {16'd0, hold_val});
      end
      bit_rise   = stream[15-2*k];
      bit_fall   = stream[14-2*k];
      lane_order = (k == 7) ? ord_end : ord_mid;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] prev;
    bit have_prev;
    #1;
    check("R1 reset word", {16'd0, word_o}, 32'd0);
    check("R1 reset strobe", {31'd0, word_vld_o}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    align = 1'b1;
    @(negedge clk);
    check("R7 strobe low during align", {31'd0, word_vld_o}, 32'd0);
    align = 1'b0;

    // R3 R4 R5: table walk, back-to-back words
    have_prev = 1'b0;
    prev = '0;
    for (int v = 0; v < NV; v++) begin
      drive_word(VECS[v].stream, ~VECS[v].ord, VECS[v].ord, have_prev, prev);
      check(VECS[v].ord ? "R4 R3 strobe" : "R5 R3 strobe", {31'd0, word_vld_o}, 32'd1);
      check(VECS[v].ord ? "R4 R3 word" : "R5 R3 word", {16'd0, word_o}, {16'd0, VECS[v].expect_w});
      prev = VECS[v].expect_w;
      have_prev = 1'b1;
    end

    // R6: order toggles mid-word, value at boundary decides
    drive_word(16'h1234, 1'b0, 1'b1, 1'b1, prev);
    check("R6 order at boundary only", {16'd0, word_o}, 32'h1234);
    drive_word(16'h1234, 1'b1, 1'b0, 1'b1, 16'h1234);
    check("R6 order at boundary only", {16'd0, word_o}, 32'h2C48);

    // R7: realign in the middle of a word
    for (int k = 0; k < 3; k++) begin
      bit_rise = 1'b1; bit_fall = 1'b1;
      @(negedge clk);
    end
    align = 1'b1;
    @(negedge clk);
    check("R7 strobe low after align", {31'd0, word_vld_o}, 32'd0);
    check("R8 word held across align", {16'd0, word_o}, 32'h2C48);
    align = 1'b0;
    drive_word(16'h00F1, 1'b1, 1'b1, 1'b1, 16'h2C48);
    check("R7 first strobe after align", {31'd0, word_vld_o}, 32'd1);
    check("R7 first word after align", {16'd0, word_o}, 32'h00F1);
    @(negedge clk);
    check("R2 strobe single cycle", {31'd0, word_vld_o}, 32'd0);

    // R1: asynchronous reset mid-run
    #3 rst_n = 1'b0;
    #1;
    check("R1 async reset word", {16'd0, word_o}, 32'd0);
    check("R1 async reset strobe", {31'd0, word_vld_o}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule